// File: doc/BRIEF.md
# DRAM Power-Up and Refresh-Init Sequencer

This block sits on the controller side of an asynchronous-strobe DRAM and owns the strobe pins from reset onward. After reset it counts out a settling interval of `CLK_MHZ * WAIT_US` clocks with every strobe held high. It then runs a fixed burst of refresh-type cycles, and only after the precharge of the last one has elapsed does it raise `init_done`. The refresh type used in the burst is a build-time choice: row-strobe-only with an explicit row address, or column-before-row.

Once initialized, the block accepts single-cycle commands through a valid/ready request port. A command can be a plain refresh, a test-mode entry cycle, or one of two test-mode exit cycles. In a test-mode entry cycle the write strobe and the column strobe both fall before the row strobe. The block remembers whether the last entry or exit sequence it issued left the memory in test mode.

Back-pressure rules: `req_ready` is high only when `init_done` is high and no strobe cycle is in flight. A command transfers on a rising clock edge where both `req_valid` and `req_ready` are high. While `req_valid` is high and the command has not yet transferred, the requester keeps `req_valid` and `req_op` unchanged. A command raised during the settling interval or the init burst therefore simply waits.

Top module: `dram_init_seq`

## Requirements
- R1: No strobe (`ras_n`, `cas_n`, `we_n`) goes low until at least `CLK_MHZ*WAIT_US` clocks after reset is released.
- R2: After the settling interval, exactly `INIT_COUNT` refresh cycles are issued before `init_done` rises. They are column-before-row cycles when `INIT_CBR`=1 and row-only cycles when `INIT_CBR`=0.
- R3: `init_done` is low from reset and rises only after at least `PRE_CYC` all-high clocks have followed the last init cycle. Once high, it stays high.
- R4: `req_ready` is never high while `init_done` is low or while a cycle is in progress. A request held from before initialization is accepted once initialization ends, and its cycle is the first cycle after the burst.
- R5: Op code 2'b01 issues a test-mode entry cycle. `cas_n` and `we_n` are both low for exactly `LEAD_CYC` clocks before `ras_n` falls.
- R6: Op code 2'b10 issues a row-only cycle: `ras_n` falls while `cas_n` and `we_n` are high. `row_addr` presents an internal row counter, which starts at 0 and increments (wrapping at `ROW_W` bits) after each row-only cycle.
- R7: Op code 2'b11 issues a column-before-row cycle: `cas_n` is low for exactly `LEAD_CYC` clocks before `ras_n` falls, and `we_n` stays high. Op code 2'b00 issues the refresh type selected by `INIT_CBR`.
- R8: Every cycle holds `ras_n` low for exactly `ACT_CYC` clocks. `cas_n` and `we_n` rise together with `ras_n`. Between cycles all strobes stay high for at least `PRE_CYC` clocks.
- R9: `test_active` is 0 after reset. It becomes 1 when an entry cycle ends, becomes 0 when any refresh-type cycle ends, and is never 1 while `init_done` is 0.
- R10: During reset, all strobes are high, `init_done`, `req_ready` and `test_active` are 0, and `row_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command request valid |
| req_op | input | 2 | Command: 00 refresh, 01 test entry, 10 exit row-only, 11 exit column-before-row |
| req_ready | output | 1 | Command can be accepted this clock |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| row_addr | output | ROW_W | Row address driven for row-only cycles |
| init_done | output | 1 | Initialization complete |
| test_active | output | 1 | Last entry/exit sequence left test mode on |

## Verification
The case to watch is the end of initialization meeting a request that has waited since reset. On the first clock after the last init precharge, `init_done` and `req_ready` rise together, and the held command is accepted at once. The bench raises a test-entry request right after reset and keeps it high through the whole wait and burst. It then checks three things: the init burst has exactly `INIT_COUNT` cycles of the configured type, `req_ready` never rose early, and the very next strobe cycle has the entry ordering with `test_active` set after it. A sweep over all four op codes follows, judged cycle by cycle from strobe edges observed at the pins.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    CYC_ROW_ONLY = 2'd0,
    CYC_CBR      = 2'd1,
    CYC_ENTRY    = 2'd2
  } cyc_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_ACT  = 2'd2,
    PH_PRE  = 2'd3
  } phase_e;

  localparam logic [1:0] OP_REFRESH  = 2'b00;
  localparam logic [1:0] OP_ENTER    = 2'b01;
  localparam logic [1:0] OP_EXIT_ROW = 2'b10;
  localparam logic [1:0] OP_EXIT_CBR = 2'b11;

endpackage

// File: rtl/dram_pwrup_timer.sv
module dram_pwrup_timer #(
  parameter int WAIT_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  output logic expired
);
  localparam int CW = $clog2(WAIT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIMIT);

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIMIT); // R1

endmodule

// File: rtl/dram_strobe_gen.sv
module dram_strobe_gen
  import dram_seq_pkg::*;
#(
  parameter int LEAD_CYC = 2,
  parameter int ACT_CYC  = 4,
  parameter int PRE_CYC  = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  cyc_kind_e kind,
  output logic      busy,
  output logic      done,
  output logic      ras_n,
  output logic      cas_n,
  output logic      we_n
);
  localparam int MAX_A = (LEAD_CYC > ACT_CYC) ? LEAD_CYC : ACT_CYC;
  localparam int MAX_L = (MAX_A > PRE_CYC) ? MAX_A : PRE_CYC;
  localparam int CW    = $clog2(MAX_L + 1);
  localparam logic [CW-1:0] LEAD_LAST = CW'(LEAD_CYC - 1);
  localparam logic [CW-1:0] ACT_LAST  = CW'(ACT_CYC - 1);
  localparam logic [CW-1:0] PRE_LAST  = CW'(PRE_CYC - 1);

  phase_e        ph;
  cyc_kind_e     kind_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      cnt    <= '0;
      kind_q <= CYC_ROW_ONLY;
    end else begin
      case (ph)
        PH_IDLE: if (start) begin
          kind_q <= kind;
          cnt    <= '0;
          ph     <= (kind == CYC_ROW_ONLY) ? PH_ACT : PH_LEAD;
        end
        PH_LEAD: if (cnt == LEAD_LAST) begin
          ph <= PH_ACT; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        PH_ACT: if (cnt == ACT_LAST) begin
          ph <= PH_PRE; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        PH_PRE: if (cnt == PRE_LAST) begin
          ph <= PH_IDLE; cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  logic col_phase;
  assign col_phase = (ph == PH_LEAD) || (ph == PH_ACT);
  assign ras_n = !(ph == PH_ACT);
  assign cas_n = !(col_phase && (kind_q != CYC_ROW_ONLY));
  assign we_n  = !(col_phase && (kind_q == CYC_ENTRY));
  assign busy  = (ph != PH_IDLE);
  assign done  = (ph == PH_PRE) && (cnt == PRE_LAST);

  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n)); // R7
  AST_CAS_RELEASE_WITH_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> $rose(ras_n)); // R8
  AST_WE_WITH_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $fell(cas_n)); // R5

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_seq_pkg::*;
#(
  parameter int CLK_MHZ    = 100,
  parameter int WAIT_US    = 200,
  parameter int INIT_COUNT = 8,
  parameter bit INIT_CBR   = 1'b1,
  parameter int LEAD_CYC   = 2,
  parameter int ACT_CYC    = 4,
  parameter int PRE_CYC    = 3,
  parameter int ROW_W      = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  output logic             req_ready,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr,
  output logic             init_done,
  output logic             test_active
);
  localparam int WAIT_CYCLES = CLK_MHZ * WAIT_US;
  localparam int IW = $clog2(INIT_COUNT + 1);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_COUNT - 1);
  localparam cyc_kind_e INIT_KIND = INIT_CBR ? CYC_CBR : CYC_ROW_ONLY;

  typedef enum logic [1:0] {T_WAIT, T_INIT, T_RUN} top_state_e;

  top_state_e     st;
  logic [IW-1:0]  init_cnt;
  cyc_kind_e      cur_kind, start_kind, req_kind;
  logic           wait_over, gen_busy, gen_done, gen_start;
  logic [ROW_W-1:0] row_q;
  logic           test_q;

  dram_pwrup_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .expired(wait_over)
  );

  always_comb begin
    case (req_op)
      OP_ENTER:    req_kind = CYC_ENTRY;
      OP_EXIT_ROW: req_kind = CYC_ROW_ONLY;
      OP_EXIT_CBR: req_kind = CYC_CBR;
      default:     req_kind = INIT_KIND;
    endcase
  end

  assign init_done  = (st == T_RUN);
  assign req_ready  = init_done && !gen_busy;
  assign gen_start  = !gen_busy && ((st == T_INIT) || ((st == T_RUN) && req_valid));
  assign start_kind = (st == T_INIT) ? INIT_KIND : req_kind;

  dram_strobe_gen #(.LEAD_CYC(LEAD_CYC), .ACT_CYC(ACT_CYC), .PRE_CYC(PRE_CYC)) u_gen (
    .clk(clk), .rst_n(rst_n), .start(gen_start), .kind(start_kind),
    .busy(gen_busy), .done(gen_done), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= T_WAIT;
      init_cnt <= '0;
      cur_kind <= CYC_ROW_ONLY;
      row_q    <= '0;
      test_q   <= 1'b0;
    end else begin
      if (gen_start) cur_kind <= start_kind;
      case (st)
        T_WAIT: if (wait_over) st <= T_INIT;
        T_INIT: if (gen_done) begin
          if (init_cnt == INIT_LAST) st <= T_RUN;
          else init_cnt <= init_cnt + 1'b1;
        end
        default: st <= T_RUN;
      endcase
      if (gen_done) begin
        test_q <= (cur_kind == CYC_ENTRY);
        if (cur_kind == CYC_ROW_ONLY) row_q <= row_q + 1'b1;
      end
    end
  end

  assign row_addr    = row_q;
  assign test_active = test_q;

  AST_QUIET_DURING_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == T_WAIT) |-> (ras_n && cas_n && we_n)); // R1
  AST_READY_NEEDS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (init_done && ras_n)); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done); // R3
  AST_TEST_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    test_active |-> init_done); // R9

endmodule

// File: tb/dram_init_seq_bench.sv
module dram_init_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT = 40;
  localparam int NINIT = 4;
  localparam int LEAD = 2;
  localparam int ACT = 3;
  localparam int PRE = 2;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic req_ready, ras_n, cas_n, we_n, init_done, test_active;
  logic [RW-1:0] row_addr;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_init_seq #(.CLK_MHZ(1), .WAIT_US(WAIT), .INIT_COUNT(NINIT), .INIT_CBR(1'b1),
    .LEAD_CYC(LEAD), .ACT_CYC(ACT), .PRE_CYC(PRE), .ROW_W(RW)) u_dram_init_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_ready(req_ready), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .row_addr(row_addr), .init_done(init_done), .test_active(test_active));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pin monitor; kinds: 0 row-only, 1 column-before-row, 2 entry
  int cyc = 0, falls = 0, cbr_seen = 0, ro_count = 0;
  int low_cnt = 0, high_cnt = 0, lead_cnt = 0, lead_we = 0, last_kind = -1;
  bit seen_active = 0, early_ready = 0, prev_ras = 1, prev_cas = 1, prev_we = 1, prev_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!seen_active && (!ras_n || !cas_n || !we_n)) begin
        seen_active = 1;
        chk(cyc >= WAIT, "R1 first strobe clock", cyc, WAIT);
      end
      if (!init_done && req_ready) early_ready = 1;
      if (prev_ras && !ras_n) begin
        falls++;
        if (prev_cas) begin
          last_kind = 0;
          chk(row_addr == RW'(ro_count), "R6 row at fall", row_addr, ro_count % 16);
          chk(cas_n && we_n, "R6 col/write high", {cas_n, we_n}, 3);
        end else begin
          last_kind = prev_we ? 1 : 2;
          chk(lead_cnt == LEAD, last_kind == 2 ? "R5 lead" : "R7 lead", lead_cnt, LEAD);
          if (last_kind == 2) chk(lead_we == LEAD, "R5 write lead", lead_we, LEAD);
        end
        if (last_kind == 1) cbr_seen++;
        if (last_kind == 0) ro_count++;
        if (falls > 1) chk(high_cnt >= PRE, "R8 precharge", high_cnt, PRE);
        low_cnt = 0;
      end
      if (!prev_ras && ras_n) begin
        chk(low_cnt == ACT, "R8 row strobe width", low_cnt, ACT);
        chk(cas_n && we_n, "R8 release together", {cas_n, we_n}, 3);
        high_cnt = 0;
      end
      if (!ras_n) low_cnt++;
      else high_cnt++;
      if (ras_n && !cas_n) lead_cnt++; else if (ras_n) lead_cnt = 0;
      if (ras_n && !we_n) lead_we++; else if (ras_n) lead_we = 0;
      if (init_done && !prev_done) begin
        chk(falls == NINIT, "R2 init cycle count", falls, NINIT);
        chk(cbr_seen == NINIT, "R2 init cycle type", cbr_seen, NINIT);
        chk(high_cnt >= PRE, "R3 done after precharge", high_cnt, PRE);
        chk(!early_ready, "R4 no early ready", early_ready, 0);
      end
      if (prev_done) chk(init_done, "R3 done sticky", init_done, 1);
      prev_ras = ras_n; prev_cas = cas_n; prev_we = we_n; prev_done = init_done;
    end
  end

  task automatic issue(input logic [1:0] op);
    req_op = op;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R4 busy back-pressure", req_ready, 0);
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R10 strobes idle", {ras_n, cas_n, we_n}, 7);
    chk(!init_done && !req_ready && !test_active, "R10 flags low",
        {init_done, req_ready, test_active}, 0);
    chk(row_addr == 0, "R10 row zero", row_addr, 0);
    rst_n = 1'b1;
    // entry request held from reset: meets the end of initialization
    issue(2'b01);
    chk(falls == NINIT + 1, "R4 held request is next cycle", falls, NINIT + 1);
    chk(last_kind == 2, "R5 entry ordering", last_kind, 2);
    chk(test_active, "R9 set by entry", test_active, 0 + 1);
    for (int i = 0; i < 24; i++) begin
      automatic logic [1:0] op = 2'(i * 3 + i / 4);
      automatic int exp_kind = (op == 2'b01) ? 2 : (op == 2'b10) ? 0 : 1;
      issue(op);
      chk(last_kind == exp_kind, op == 2'b10 ? "R6 row-only kind" : "R7 cycle kind",
          last_kind, exp_kind);
      chk(test_active == (op == 2'b01), "R9 test flag", test_active, op == 2'b01);
      chk(row_addr == RW'(ro_count), "R6 row counter", row_addr, ro_count % 16);
    end
    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule